// File: doc/BRIEF.md
# XY Mesh Route Computation Unit

This block computes the output direction for one input port of a five-port router in a two-dimensional mesh. The router's own column and row are fixed by parameters. When a packet's first flit reaches the front of the input port, the block reads the destination column and row from the top of that flit. It resolves the column first and the row second. It then raises a one-hot request toward the Local, East, West, North or South output.

The request stays up, unchanged, until the switch allocator grants it. Once granted, the path stays locked for the whole packet. A flit at the head of the input is forwarded on any cycle the path is locked and a flit is present. The forward strobe never rises before the grant, so a busy output stalls the header and every later flit of the same packet. The lock and the request drop on the cycle after the flit carrying the tail mark is forwarded. The block can then accept the next header.

The controller has three states: `ST_IDLE`, `ST_WAIT_GRANT` and `ST_LOCKED`. It has four transitions:
- `T_HEAD_SEEN`: from `ST_IDLE` to `ST_WAIT_GRANT` when a flit is present.
- `T_GRANTED`: from `ST_WAIT_GRANT` to `ST_LOCKED` on a grant.
- `T_TAIL_GONE`: from `ST_LOCKED` to `ST_IDLE` when the tail flit is forwarded.
- `T_HOLD`: every other case, where the state is unchanged.

Top module: `xy_route_unit`

## Requirements
- R1: When the destination column and row both equal the router's own, the request is bit 0 (Local).
- R2: The column is compared first. If the destination column is greater, the request is bit 1 (East). If it is smaller, the request is bit 2 (West). This holds whatever the destination row is.
- R3: When the columns are equal, the row decides. A greater destination row requests bit 4 (South). A smaller one requests bit 3 (North).
- R4: The destination column sits in header bits [39:36] and the row in bits [35:32]. The `hdr_coord` port carries header bits [39:32]. The request appears one cycle after a flit is present while idle.
- R5: While waiting for a grant, the request is held unchanged. Changes on `hdr_coord`, `flit_tail` and `flit_valid` have no effect on it.
- R6: A grant while waiting sets `path_locked` on the next cycle. The request stays asserted while the path is locked.
- R7: `flit_fwd` equals `flit_valid` while the path is locked and is 0 otherwise. The header and every following flit stall until the grant.
- R8: When a flit with `flit_tail` high is forwarded, the request and the lock are both 0 on the next cycle. A new header is taken from then on.
- R9: `route_grant` has no effect while idle or locked.
- R10: During and right after reset, the request is 0, the path is unlocked and `flit_fwd` is 0. At most one request bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is at the head of the input port |
| flit_tail | input | 1 | The head flit is the last flit of its packet |
| hdr_coord | input | 2*COORD_W | Header bits [39:32]: destination column (upper half) and row (lower half) |
| route_grant | input | 1 | The allocator grants this port's request |
| route_req | output | 5 | One-hot request: 0 Local, 1 East, 2 West, 3 North, 4 South |
| path_locked | output | 1 | The granted path is held for the current packet |
| flit_fwd | output | 1 | The head flit is forwarded this cycle |

## Verification
The request is registered and is due one clock after a header is seen while idle. The lock is due one clock after a grant while waiting. Both drop one clock after a tail is forwarded. `flit_fwd` is combinational and is due in the same cycle as `flit_valid`, provided the path is locked. The bench drives inputs just after the falling edge and compares all outputs before the next rising edge against a behavioural model. The model advances its state only after each comparison, so every expected value lines up with the register count above.

// File: rtl/xy_route_pkg.sv
package xy_route_pkg;

    localparam int NUM_DIRS = 5;

    localparam int DIR_LOCAL = 0;
    localparam int DIR_EAST  = 1;
    localparam int DIR_WEST  = 2;
    localparam int DIR_NORTH = 3;
    localparam int DIR_SOUTH = 4;

    typedef logic [NUM_DIRS-1:0] dir_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_GRANT = 2'd1,
        ST_LOCKED     = 2'd2
    } route_state_t;

endpackage

// File: rtl/xy_dim_order.sv
module xy_dim_order
    import xy_route_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 3
) (
    input  logic [2*COORD_W-1:0] coord,
    output dir_vec_t             dir
);
    localparam logic [COORD_W-1:0] CX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] CY = COORD_W'(MY_Y);

    logic [COORD_W-1:0] dst_x;
    logic [COORD_W-1:0] dst_y;

    assign dst_x = coord[2*COORD_W-1 -: COORD_W];
    assign dst_y = coord[COORD_W-1:0];

    always_comb begin
        dir = '0;
        if (dst_x > CX) begin
            dir[DIR_EAST] = 1'b1;
        end else if (dst_x < CX) begin
            dir[DIR_WEST] = 1'b1;
        end else if (dst_y > CY) begin
            dir[DIR_SOUTH] = 1'b1;
        end else if (dst_y < CY) begin
            dir[DIR_NORTH] = 1'b1;
        end else begin
            dir[DIR_LOCAL] = 1'b1;
        end
    end

    always_comb begin
        assert ($onehot(dir)) else $error("p_dir_onehot_r10: decode result not one-hot");
    end

endmodule

// File: rtl/xy_route_fsm.sv
module xy_route_fsm
    import xy_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flit_valid,
    input  logic     flit_tail,
    input  logic     route_grant,
    input  dir_vec_t dir_in,
    output dir_vec_t req_q,
    output logic     locked,
    output logic     fwd
);
    route_state_t state_q;
    route_state_t state_d;
    dir_vec_t     req_d;

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flit_valid) begin
                    state_d = ST_WAIT_GRANT;
                    req_d   = dir_in;
                end
            end
            ST_WAIT_GRANT: begin
                if (route_grant) begin
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (flit_valid && flit_tail) begin
                    state_d = ST_IDLE;
                    req_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                req_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    always_comb begin
        locked = (state_q == ST_LOCKED);
        fwd    = (state_q == ST_LOCKED) && flit_valid;
    end

    p_req_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_q));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_GRANT) |=> $stable(req_q));

    p_lock_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_GRANT && route_grant) |=> locked);

    p_locked_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (req_q != '0));

    p_no_fwd_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !fwd);

    p_release_on_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && flit_tail) |=> (req_q == '0 && !locked));

    p_idle_grant_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !flit_valid) |=> (req_q == '0 && !locked));

endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
    import xy_route_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flit_valid,
    input  logic                 flit_tail,
    input  logic [2*COORD_W-1:0] hdr_coord,
    input  logic                 route_grant,
    output logic [4:0]           route_req,
    output logic                 path_locked,
    output logic                 flit_fwd
);
    dir_vec_t dir_w;
    dir_vec_t req_w;

    xy_dim_order #(
        .COORD_W (COORD_W),
        .MY_X    (MY_X),
        .MY_Y    (MY_Y)
    ) u_dim_order (
        .coord (hdr_coord),
        .dir   (dir_w)
    );

    xy_route_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flit_valid  (flit_valid),
        .flit_tail   (flit_tail),
        .route_grant (route_grant),
        .dir_in      (dir_w),
        .req_q       (req_w),
        .locked      (path_locked),
        .fwd         (flit_fwd)
    );

    assign route_req = req_w;

endmodule

// File: tb/xy_route_unit_bench.sv
module xy_route_unit_bench;
    localparam int CW   = 4;
    localparam int MX   = 2;
    localparam int MY   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flit_valid = 1'b0;
    logic       flit_tail = 1'b0;
    logic [39:0] flit = '0;
    logic       route_grant = 1'b0;
    logic [4:0] route_req;
    logic       path_locked;
    logic       flit_fwd;

    int n_cmp = 0;
    int n_bad = 0;
    int m_state = 0;
    int m_req = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xy_route_unit #(.COORD_W(CW), .MY_X(MX), .MY_Y(MY)) u_xy_route_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .flit_valid  (flit_valid),
        .flit_tail   (flit_tail),
        .hdr_coord   (flit[39:32]),
        .route_grant (route_grant),
        .route_req   (route_req),
        .path_locked (path_locked),
        .flit_fwd    (flit_fwd)
    );

    function automatic int ref_dir(int dx, int dy);
        if (dx > MX) return 2;
        if (dx < MX) return 4;
        if (dy > MY) return 16;
        if (dy < MY) return 8;
        return 1;
    endfunction

    function automatic logic [39:0] mk(int dx, int dy, logic [31:0] body);
        return {dx[3:0], dy[3:0], body};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic v, logic t, logic [39:0] d, logic g, string tag);
        flit_valid  = v;
        flit_tail   = t;
        flit        = d;
        route_grant = g;
        #1;
        chk({tag, " R2/R3/R5 route_req"}, int'(route_req), m_req);
        chk({tag, " R6 path_locked"}, int'(path_locked), (m_state == 2) ? 1 : 0);
        chk({tag, " R7 flit_fwd"}, int'(flit_fwd), (m_state == 2 && v) ? 1 : 0);
        case (m_state)
            0: if (v) begin m_state = 1; m_req = ref_dir(int'(d[39:36]), int'(d[35:32])); end
            1: if (g) m_state = 2;
            2: if (v && t) begin m_state = 0; m_req = 0; end
            default: m_state = 0;
        endcase
        @(negedge clk);
    endtask

    task automatic packet(int dx, int dy, int wait_cyc, int body_len, string tag);
        step(1'b1, body_len == 0, mk(dx, dy, 32'h1111_0000), 1'b0, {tag, " head"});
        for (int i = 0; i < wait_cyc; i++)
            step(1'b1, i[0], mk(15 - dx, 15 - dy, 32'(i)), 1'b0, {tag, " wait R5"});
        step(1'b1, body_len == 0, mk(dx, dy, 32'h2222_0000), 1'b1, {tag, " grant R6"});
        step(1'b1, body_len == 0, mk(dx, dy, 32'h3333_0000), 1'b0, {tag, " head fwd R7"});
        for (int i = 1; i <= body_len; i++) begin
            step(1'b0, 1'b1, mk(0, 0, 0), 1'b1, {tag, " gap R7/R9"});
            step(1'b1, i == body_len, mk(7, 7, 32'(i)), 1'b0, {tag, " body R8"});
        end
        step(1'b0, 1'b0, mk(0, 0, 0), 1'b0, {tag, " after tail R8"});
    endtask

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, mk(9, 9, 0), 1'b1, "reset R10");
        m_state = 0;
        m_req = 0;
        step(1'b1, 1'b0, mk(9, 9, 0), 1'b1, "reset R10");
        m_state = 0;
        m_req = 0;
        rst_n = 1'b1;
        flit_valid = 1'b0;
        #1;
        chk("post-reset R10 route_req", int'(route_req), 0);
        @(negedge clk);
        // R9: grants while idle with no flit do nothing
        step(1'b0, 1'b0, mk(0, 0, 0), 1'b1, "idle grant R9");
        step(1'b0, 1'b1, mk(0, 0, 0), 1'b1, "idle grant R9");
        packet(MX, MY, 2, 1, "local R1");
        packet(MX + 1, 0, 0, 0, "east R2");
        packet(15, 15, 3, 2, "east corner R2");
        packet(MX - 1, 15, 1, 1, "west R2");
        packet(0, 0, 0, 0, "west corner R2");
        packet(MX, MY + 1, 2, 0, "south R3");
        packet(MX, 15, 0, 1, "south edge R3");
        packet(MX, MY - 1, 1, 3, "north R3");
        packet(MX, 0, 4, 0, "north edge R3");
        // R4: back-to-back, header follows right after tail
        step(1'b1, 1'b0, mk(MX, MY, 0), 1'b0, "b2b head R4");
        step(1'b1, 1'b0, mk(0, 0, 0), 1'b1, "b2b grant R6");
        step(1'b1, 1'b1, mk(0, 0, 0), 1'b1, "b2b tail R8/R9");
        step(1'b1, 1'b0, mk(MX + 3, MY, 0), 1'b0, "b2b next head R4");
        step(1'b0, 1'b0, mk(0, 0, 0), 1'b1, "b2b grant R6");
        step(1'b1, 1'b0, mk(0, 0, 0), 1'b1, "locked body R9");
        step(1'b1, 1'b1, mk(0, 0, 0), 1'b0, "locked tail R8");
        step(1'b0, 1'b0, mk(0, 0, 0), 1'b0, "idle R8");
        for (int k = 0; k < 40; k++)
            packet((k * 7) % 16, (k * 5) % 16, k % 3, k % 4, "sweep R1/R2/R3");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1'b1;
        $finish;
    end
endmodule